// File: doc/BRIEF.md
# Snoop Write-Back Responder

This block is the processor-side agent that answers external snoops on a write-back cache. While an outside bus master holds the bus, the system presents a snoop address with a strobe and a kill qualifier. The block looks up a small direct-mapped tag and state array. If the snooped line is modified, it raises a dirty-hit flag. Once the hold request is withdrawn, it copies the line out to memory as a burst write. It then lowers the flag and downgrades the line.

A hit on a clean line needs no bus cycle: the block downgrades the line in place. A miss leaves the array untouched. The block also generates the hold acknowledge. The acknowledge waits until the core's own bus access has been quiet for two cycles, and it stays low while a write-back owns the bus.

Line states use the 2-bit encoding INVALID = 00, SHARED = 01, EXCLUSIVE = 10, MODIFIED = 11. A snoop address splits into tag, index and byte offset; with the defaults these are bits 31:7, 6:4 and 3:0. All control signals are active high.

Top module: `swb_snoop_responder`

## Requirements
- R1: A snoop strobe taken while `hold_ack` is high sets `dirty_hit` high exactly two clocks later, provided the addressed line is valid, its tag matches and its state is MODIFIED (11).
- R2: A matching hit on a SHARED (01) or EXCLUSIVE (10) line leaves `dirty_hit` low and starts no bus cycle. Two clocks after the strobe, the line reads SHARED if `snoop_kill` was 0 and INVALID (00) if it was 1.
- R3: A snoop whose tag differs, or whose line is INVALID, changes no line state, leaves `dirty_hit` low and starts no bus cycle.
- R4: The write-back begins with a one-clock `bus_addr_strobe` with `bus_write` and `bus_cacheable` high. `bus_addr` carries the line base (tag, index, zero offset). The strobe comes no earlier than the second clock after `hold_req` is first seen low, so at least one idle clock lies between the two.
- R5: The burst then moves BEATS data beats, beat k on `bus_data[DATA_W-1:0]` = bits k*DATA_W upward of the line. Each beat is held until `bus_rdy` is sampled high. `bus_last` is high only during the final beat.
- R6: In the clock after the final beat is accepted, `dirty_hit` is low again. The line then reads SHARED if the causing snoop had `snoop_kill` = 0, and INVALID if it had 1.
- R7: From a modified hit until its write-back ends, further snoop strobes are ignored: they change no line state and do not alter the line being written back.
- R8: A snoop strobe arriving while `hold_ack` is low is ignored.
- R9: `hold_ack` rises only after `hold_req` is high and the bus has been quiet for two clock samples. The bus counts as busy while `cpu_busy` is high or a write-back runs. `hold_ack` is low during a write-back, and it is low in the clock after `hold_req` is sampled low.
- R10: After reset every line reads INVALID and `hold_ack`, `dirty_hit` and all bus strobes are low.
- R11: A `fill_en` pulse writes `fill_tag` and `fill_state` into the line at `fill_index`, readable on `probe_state` in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_req | input | 1 | Outside master asks for the bus |
| hold_ack | output | 1 | Bus granted to the outside master |
| cpu_busy | input | 1 | Core's own bus access in progress |
| snoop_strobe | input | 1 | Snoop address valid |
| snoop_kill | input | 1 | 1: line ends INVALID, 0: line ends SHARED |
| snoop_addr | input | ADDR_W | Snooped byte address |
| dirty_hit | output | 1 | Snoop hit a modified line; write-back pending or running |
| fill_en | input | 1 | Install a line entry |
| fill_index | input | IDX_W | Line index to install |
| fill_tag | input | TAG_W | Tag to install |
| fill_state | input | 2 | State to install |
| probe_index | input | IDX_W | Line index to read back |
| probe_state | output | 2 | State of the probed line |
| line_index | output | IDX_W | Index of the snooped line for the data array |
| line_data | input | BEATS*DATA_W | Whole line read from the data array |
| bus_addr_strobe | output | 1 | Address phase of the write-back |
| bus_write | output | 1 | Write direction during the write-back |
| bus_cacheable | output | 1 | Burst line transfer marker |
| bus_last | output | 1 | Final beat of the burst |
| bus_rdy | input | 1 | Memory accepts the current beat |
| bus_addr | output | ADDR_W | Line base address |
| bus_data | output | DATA_W | Current beat of write data |

## Verification
Several rules are checked on every clock by properties:
- `dirty_hit` never rises without a strobe two clocks before, and never falls except right after an accepted last beat.
- The address strobe never follows a high hold request or a high acknowledge in the previous clock.
- `bus_last` appears only inside the write phase, and the write phase only under `dirty_hit`.
- The acknowledge never rises right after a busy clock and never overlaps a write-back.

Only the bench scenarios can show which line state a snoop leaves behind, the data order across wait states, and that snoops during a pending write-back or without the acknowledge leave the array untouched.

// File: rtl/swb_pkg.sv
package swb_pkg;

   typedef enum logic [1:0] {
      LS_INVALID = 2'b00,
      LS_SHARED  = 2'b01,
      LS_EXCL    = 2'b10,
      LS_MOD     = 2'b11
   } line_state_t;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_LOOKUP,
      FS_PEND,
      FS_ADDR,
      FS_DATA
   } wb_fsm_t;

endpackage

// File: rtl/swb_tag_array.sv
module swb_tag_array
   import swb_pkg::*;
#(
   parameter int LINES = 8,
   parameter int TAG_W = 25,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  line_state_t      wr_state,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  line_state_t      upd_state,
   input  logic [IDX_W-1:0] lk_idx,
   output logic [TAG_W-1:0] lk_tag,
   output line_state_t      lk_state,
   input  logic [IDX_W-1:0] pb_idx,
   output line_state_t      pb_state
);

   logic [TAG_W-1:0] tag_all [LINES];
   line_state_t      st_all  [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [TAG_W-1:0] tag_r;
      line_state_t      st_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_r <= '0;
            st_r  <= LS_INVALID;
         end else if (upd_en && upd_idx == IDX_W'(i)) begin
            st_r <= upd_state;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            tag_r <= wr_tag;
            st_r  <= wr_state;
         end
      end

      assign tag_all[i] = tag_r;
      assign st_all[i]  = st_r;
   end

   assign lk_tag   = tag_all[lk_idx];
   assign lk_state = st_all[lk_idx];
   assign pb_state = st_all[pb_idx];

endmodule

// File: rtl/swb_hold_ctrl.sv
module swb_hold_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_req,
   input  logic busy,
   output logic hold_ack
);

   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b1;
         hold_ack <= 1'b0;
      end else begin
         busy_q   <= busy;
         hold_ack <= hold_req && !busy && !busy_q;
      end
   end

endmodule

// File: rtl/swb_line_buf.sv
module swb_line_buf #(
   parameter int DATA_W = 32,
   parameter int BEATS  = 4,
   localparam int BEAT_W = $clog2(BEATS),
   localparam int LINE_W = BEATS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LINE_W-1:0] line_in,
   input  logic [BEAT_W-1:0] sel,
   output logic [DATA_W-1:0] beat_out
);

   logic [LINE_W-1:0] buf_q;
   logic [DATA_W-1:0] slice [BEATS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    buf_q <= '0;
      else if (load) buf_q <= line_in;
   end

   for (genvar b = 0; b < BEATS; b++) begin : g_slice
      assign slice[b] = buf_q[b*DATA_W +: DATA_W];
   end

   assign beat_out = slice[sel];

endmodule

// File: rtl/swb_snoop_responder.sv
module swb_snoop_responder
   import swb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int BEATS  = 4,
   parameter int LINES  = 8,
   localparam int LINE_BYTES = BEATS * DATA_W / 8,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int IDX_W  = $clog2(LINES),
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
   localparam int BEAT_W = $clog2(BEATS),
   localparam int LINE_W = BEATS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_req,
   output logic              hold_ack,
   input  logic              cpu_busy,
   input  logic              snoop_strobe,
   input  logic              snoop_kill,
   input  logic [ADDR_W-1:0] snoop_addr,
   output logic              dirty_hit,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_index,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [1:0]        fill_state,
   input  logic [IDX_W-1:0]  probe_index,
   output logic [1:0]        probe_state,
   output logic [IDX_W-1:0]  line_index,
   input  logic [LINE_W-1:0] line_data,
   output logic              bus_addr_strobe,
   output logic              bus_write,
   output logic              bus_cacheable,
   output logic              bus_last,
   input  logic              bus_rdy,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data
);

   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("BEATS must be a power of two of at least 2");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W leaves no tag bits");
   end

   wb_fsm_t          st_q;
   logic [TAG_W-1:0] cap_tag;
   logic [IDX_W-1:0] cap_idx;
   logic             cap_kill;
   logic [BEAT_W-1:0] beat_q;
   logic             dirty_q;

   logic [TAG_W-1:0] lk_tag;
   line_state_t      lk_state;
   line_state_t      pb_state;
   logic             lk_hit, mod_hit, clean_hit;
   logic             last_beat, wb_on_bus, snoop_take;
   logic             upd_en;
   line_state_t      fin_state;
   logic             unused_offset;

   assign unused_offset = ^snoop_addr[OFF_W-1:0];

   assign lk_hit    = (lk_state != LS_INVALID) && (lk_tag == cap_tag);
   assign mod_hit   = (st_q == FS_LOOKUP) && lk_hit && (lk_state == LS_MOD);
   assign clean_hit = (st_q == FS_LOOKUP) && lk_hit && (lk_state != LS_MOD);
   assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
   assign wb_on_bus = (st_q == FS_ADDR) || (st_q == FS_DATA);
   assign snoop_take = (st_q == FS_IDLE) && snoop_strobe && hold_ack;
   assign fin_state = cap_kill ? LS_INVALID : LS_SHARED;
   assign upd_en    = clean_hit || ((st_q == FS_DATA) && bus_rdy && last_beat);

   swb_tag_array #(
      .LINES (LINES),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (fill_en),
      .wr_idx    (fill_index),
      .wr_tag    (fill_tag),
      .wr_state  (line_state_t'(fill_state)),
      .upd_en    (upd_en),
      .upd_idx   (cap_idx),
      .upd_state (fin_state),
      .lk_idx    (cap_idx),
      .lk_tag    (lk_tag),
      .lk_state  (lk_state),
      .pb_idx    (probe_index),
      .pb_state  (pb_state)
   );

   swb_hold_ctrl u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_req (hold_req),
      .busy     (cpu_busy || wb_on_bus),
      .hold_ack (hold_ack)
   );

   swb_line_buf #(
      .DATA_W (DATA_W),
      .BEATS  (BEATS)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (mod_hit),
      .line_in  (line_data),
      .sel      (beat_q),
      .beat_out (bus_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= FS_IDLE;
         cap_tag  <= '0;
         cap_idx  <= '0;
         cap_kill <= 1'b0;
         beat_q   <= '0;
         dirty_q  <= 1'b0;
      end else begin
         case (st_q)
            FS_IDLE: begin
               if (snoop_take) begin
                  cap_tag  <= snoop_addr[ADDR_W-1 -: TAG_W];
                  cap_idx  <= snoop_addr[OFF_W +: IDX_W];
                  cap_kill <= snoop_kill;
                  st_q     <= FS_LOOKUP;
               end
            end
            FS_LOOKUP: begin
               if (mod_hit) begin
                  dirty_q <= 1'b1;
                  st_q    <= FS_PEND;
               end else begin
                  st_q <= FS_IDLE;
               end
            end
            FS_PEND: begin
               if (!hold_req && !hold_ack) st_q <= FS_ADDR;
            end
            FS_ADDR: begin
               beat_q <= '0;
               st_q   <= FS_DATA;
            end
            FS_DATA: begin
               if (bus_rdy) begin
                  if (last_beat) begin
                     dirty_q <= 1'b0;
                     st_q    <= FS_IDLE;
                  end else begin
                     beat_q <= beat_q + 1'b1;
                  end
               end
            end
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   assign dirty_hit       = dirty_q;
   assign probe_state     = pb_state;
   assign line_index      = cap_idx;
   assign bus_addr_strobe = (st_q == FS_ADDR);
   assign bus_write       = wb_on_bus;
   assign bus_cacheable   = (st_q == FS_ADDR);
   assign bus_last        = (st_q == FS_DATA) && last_beat;
   assign bus_addr        = {cap_tag, cap_idx, {OFF_W{1'b0}}};

endmodule

// File: rtl/swb_snoop_responder_chk.sv
module swb_snoop_responder_chk (
   input logic clk,
   input logic rst_n,
   input logic hold_req,
   input logic hold_ack,
   input logic cpu_busy,
   input logic snoop_strobe,
   input logic dirty_hit,
   input logic bus_addr_strobe,
   input logic bus_write,
   input logic bus_cacheable,
   input logic bus_last,
   input logic bus_rdy
);

   AST_HIT_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dirty_hit) |-> $past(snoop_strobe, 2));  // R1

   AST_ADS_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr_strobe |-> bus_write && bus_cacheable && dirty_hit);  // R4

   AST_ADS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr_strobe |-> !$past(hold_req) && !$past(hold_ack));  // R4

   AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      bus_last |-> bus_write && !bus_addr_strobe && !bus_cacheable);  // R5

   AST_WB_UNDER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_write |-> dirty_hit);  // R5

   AST_HIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dirty_hit) |-> $past(bus_last && bus_rdy));  // R6

   AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack) |-> !$past(cpu_busy) && !$past(bus_write));  // R9

   AST_ACK_NOT_WB: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> !bus_write);  // R9

   AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_req |=> !hold_ack);  // R9

endmodule

bind swb_snoop_responder swb_snoop_responder_chk u_chk (.*);

// File: tb/swb_snoop_responder_bench.sv
`timescale 1ns/1ps
module swb_snoop_responder_bench;

   localparam int AW = 32, DW = 32, NB = 4, NL = 8;
   localparam int IW = 3, TW = 25;
   localparam logic [TW-1:0] TAGB = 25'h0_1234;

   // fields: [11] kill [10:8] idx [7] tag match [6:5] initial state
   //         [4:3] wait clocks per beat [2] expected dirty hit [1:0] expected final state
   localparam logic [11:0] VEC [8] = '{
      {1'b0, 3'd1, 1'b1, 2'd3, 2'd0, 1'b1, 2'd1},
      {1'b1, 3'd2, 1'b1, 2'd3, 2'd1, 1'b1, 2'd0},
      {1'b0, 3'd3, 1'b1, 2'd2, 2'd0, 1'b0, 2'd1},
      {1'b1, 3'd4, 1'b1, 2'd1, 2'd0, 1'b0, 2'd0},
      {1'b0, 3'd5, 1'b0, 2'd3, 2'd0, 1'b0, 2'd3},
      {1'b1, 3'd6, 1'b1, 2'd0, 2'd0, 1'b0, 2'd0},
      {1'b1, 3'd7, 1'b1, 2'd2, 2'd0, 1'b0, 2'd0},
      {1'b0, 3'd0, 1'b1, 2'd3, 2'd2, 1'b1, 2'd1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic hold_req = 1'b0, cpu_busy = 1'b0, snoop_strobe = 1'b0, snoop_kill = 1'b0;
   logic [AW-1:0] snoop_addr = '0;
   logic fill_en = 1'b0;
   logic [IW-1:0] fill_index = '0, probe_index = '0;
   logic [TW-1:0] fill_tag = '0;
   logic [1:0] fill_state = '0;
   logic bus_rdy = 1'b0;
   logic hold_ack, dirty_hit, bus_addr_strobe, bus_write, bus_cacheable, bus_last;
   logic [1:0] probe_state;
   logic [IW-1:0] line_index;
   logic [NB*DW-1:0] line_data;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data;

   int total = 0, bad = 0, ads_cnt = 0, exp_ads = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   function automatic logic [DW-1:0] beat_val(logic [IW-1:0] i, int b);
      return 32'hA500_0000 | (32'(i) << 8) | 32'(b);
   endfunction

   function automatic logic [NB*DW-1:0] mk_line(logic [IW-1:0] i);
      logic [NB*DW-1:0] l;
      for (int b = 0; b < NB; b++) l[b*DW +: DW] = beat_val(i, b);
      return l;
   endfunction

   assign line_data = mk_line(line_index);

   swb_snoop_responder u_swb_snoop_responder (.*);

   always @(negedge clk) if (bus_addr_strobe) ads_cnt++;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_ack();
      for (int n = 0; n < 20 && !hold_ack; n++) @(negedge clk);
      chk("R9 hold_ack granted", 64'(hold_ack), 64'd1);
   endtask

   task automatic install(logic [IW-1:0] i, logic [TW-1:0] t, logic [1:0] s);
      fill_en = 1'b1; fill_index = i; fill_tag = t; fill_state = s;
      @(negedge clk);
      fill_en = 1'b0;
      probe_index = i;
      #0 chk("R11 installed state", 64'(probe_state), 64'(s));
   endtask

   task automatic snoop(logic [IW-1:0] i, logic [TW-1:0] t, logic k);
      snoop_strobe = 1'b1; snoop_kill = k; snoop_addr = {t, i, 4'h0};
      @(negedge clk);
      snoop_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic write_back(logic [IW-1:0] i, int waits, logic [1:0] fin);
      hold_req = 1'b0;
      @(negedge clk);
      chk("R4 idle clock before strobe", 64'(bus_addr_strobe), 64'd0);
      @(negedge clk);
      chk("R4 address strobe", 64'(bus_addr_strobe), 64'd1);
      chk("R4 write and cacheable", 64'({bus_write, bus_cacheable}), 64'd3);
      chk("R4 line address", 64'(bus_addr), 64'({TAGB + TW'(i), i, 4'h0}));
      exp_ads++;
      hold_req = 1'b1;
      @(negedge clk);
      for (int b = 0; b < NB; b++) begin
         for (int w = 0; w < waits; w++) begin
            chk("R9 ack low in burst", 64'(hold_ack), 64'd0);
            @(negedge clk);
         end
         chk("R5 beat data", 64'(bus_data), 64'(beat_val(i, b)));
         chk("R5 last marker", 64'(bus_last), 64'(b == NB - 1));
         chk("R6 hit held in burst", 64'(dirty_hit), 64'd1);
         bus_rdy = 1'b1;
         @(negedge clk);
         bus_rdy = 1'b0;
      end
      chk("R6 dirty_hit cleared", 64'(dirty_hit), 64'd0);
      probe_index = i;
      #0 chk("R6 final line state", 64'(probe_state), 64'(fin));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 hold_ack", 64'(hold_ack), 64'd0);
      chk("R10 dirty_hit", 64'(dirty_hit), 64'd0);
      chk("R10 bus strobes", 64'({bus_addr_strobe, bus_write, bus_last}), 64'd0);
      for (int i = 0; i < NL; i++) begin
         probe_index = IW'(i);
         #0 chk("R10 line invalid", 64'(probe_state), 64'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R9 hold acknowledge waits for a quiet bus
      cpu_busy = 1'b1; hold_req = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9 ack blocked by busy", 64'(hold_ack), 64'd0);
      cpu_busy = 1'b0;
      @(negedge clk);
      chk("R9 ack after one quiet clock", 64'(hold_ack), 64'd0);
      @(negedge clk);
      chk("R9 ack after two quiet clocks", 64'(hold_ack), 64'd1);
      hold_req = 1'b0;
      @(negedge clk);
      chk("R9 ack drops with request", 64'(hold_ack), 64'd0);

      // table walk
      for (int v = 0; v < 8; v++) begin
         logic k; logic [IW-1:0] i; logic m; logic [1:0] s0, fin; int w; logic eh;
         logic [TW-1:0] t;
         {k, i, m, s0} = VEC[v][11:5];
         w = int'(VEC[v][4:3]); eh = VEC[v][2]; fin = VEC[v][1:0];
         t = TAGB + TW'(i);
         hold_req = 1'b1;
         wait_ack();
         install(i, t, s0);
         snoop(i, m ? t : t ^ TW'(1), k);
         chk(eh ? "R1 dirty hit" : "R2 R3 no dirty hit", 64'(dirty_hit), 64'(eh));
         if (eh) write_back(i, w, fin);
         else begin
            probe_index = i;
            #0 chk(m ? "R2 clean hit state" : "R3 miss state", 64'(probe_state), 64'(fin));
         end
         chk("R2 R3 bus cycle count", 64'(ads_cnt), 64'(exp_ads));
      end

      // R7 snoops ignored while a write-back is pending
      hold_req = 1'b1;
      wait_ack();
      install(3'd2, TAGB + 25'd2, 2'd3);
      install(3'd3, TAGB + 25'd3, 2'd3);
      snoop(3'd2, TAGB + 25'd2, 1'b0);
      chk("R1 hit before pending snoop", 64'(dirty_hit), 64'd1);
      snoop(3'd3, TAGB + 25'd3, 1'b1);
      probe_index = 3'd3;
      #0 chk("R7 second line untouched", 64'(probe_state), 64'd3);
      write_back(3'd2, 0, 2'd1);
      repeat (4) @(negedge clk);
      chk("R7 single write-back", 64'(ads_cnt), 64'(exp_ads));
      probe_index = 3'd3;
      #0 chk("R7 second line still modified", 64'(probe_state), 64'd3);

      // R8 snoop without acknowledge ignored
      hold_req = 1'b0;
      repeat (2) @(negedge clk);
      install(3'd5, TAGB + 25'd5, 2'd3);
      snoop(3'd5, TAGB + 25'd5, 1'b1);
      chk("R8 no hit without ack", 64'(dirty_hit), 64'd0);
      probe_index = 3'd5;
      #0 chk("R8 line unchanged", 64'(probe_state), 64'd3);
      repeat (3) @(negedge clk);
      chk("R8 no bus cycle", 64'(ads_cnt), 64'(exp_ads));

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule